// File: doc/BRIEF.md
# Compare/capture timer channel

A single timer channel built around a 16-bit up counter and two general registers. A counter tick comes from one of two kinds of source. The first is the system clock divided by 1, 2, 4 or 8. The second is an edge of one of four external clock pins, after synchronisation. Each general register is given a 3-bit mode. In a compare mode it watches the counter and can drive its own output pin low, high or toggle on a match. In a capture mode it copies the counter when a chosen edge arrives on its own input pin.

The counter can run free and wrap, or it can clear itself from an event on either general register, which makes a periodic interval timer. Three sticky flags record events on register A, events on register B, and counter overflow. Three enable bits gate these flags onto three interrupt lines. Software reaches all state through a word-wide register bus.

Register map (word addresses): 0 control, 1 pin modes, 2 flags, 3 interrupt enables, 4 counter, 5 general register A, 6 general register B. Control word: bit 0 run, bits 3:1 source, bits 5:4 edge, bits 7:6 clear mode. Pin-mode word: bits 2:0 register A mode, bits 6:4 register B mode. Flags and enables: bit 0 A, bit 1 B, bit 2 overflow.

Top module: `cmpcap_timer`

## Requirements
- R1: The counter changes only on a tick while the run bit is 1, or on a bus write to it. While run is 0 there are no compare or capture events, no flag sets and no pin changes.
- R2: Source codes 0 to 3 tick once every 1, 2, 4 or 8 system cycles. A free 3-bit phase counter starts at 0 on reset, and the tick falls on the cycles in which its low 0/1/2/3 bits are all ones.
- R3: Source codes 4 to 7 select external pin 0 to 3. The edge field selects the rising edge (00), the falling edge (01) or both edges (1x). The counter steps on the third rising system-clock edge after the pin changes, so counting on both edges adds two per pin period.
- R4: Clear mode 00 or 11 runs free. A tick at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag, unless a clear or a bus write to the counter takes that cycle.
- R5: Clear mode 01 or 10 clears the counter on an event of register A or B. A compare match is the tick at which the counter already equals the register, so a value N gives a period of N+1 ticks.
- R6: Compare mode codes: 000 gives a match with no pin change, 001 drives the pin to 0, 010 drives it to 1, and 011 inverts it. The pins reset to 0.
- R7: Capture mode codes: 100 captures on a rising edge of the synchronised input pin, 101 on a falling edge, and 110/111 on both. A capture copies the current counter into the register, and in the matching clear mode it also clears the counter.
- R8: A flag sets on its event. A bus write of 0 to a flag bit clears it, a write of 1 leaves it as it is, and an event in the same cycle as a clearing write keeps the flag set.
- R9: Each interrupt output equals its flag AND its enable bit, updated in the same cycle as the flag.
- R10: A bus write to the counter overrides a count or a clear in the same cycle.
- R11: Read data is registered. It shows the addressed register one cycle after the address is presented, and all registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_clk | input | 4 | External count clock pins |
| cap_in | input | 2 | Capture input pins, bit 0 for A, bit 1 for B |
| cmp_out | output | 2 | Compare output pins, bit 0 for A, bit 1 for B |
| irq_a | output | 1 | Register A event interrupt |
| irq_b | output | 1 | Register B event interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The assertions assume that every external clock pin and capture pin holds each level for at least two system cycles. They also assume that reset is held until the first edges have loaded the synchroniser flops. The stimulus holds pin levels for three or more cycles and changes inputs only on falling clock edges. Bus writes are single-cycle strobes, and the bus address rests on the counter between accesses, so the count is visible on the read port nearly every cycle.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int N_GR   = 2;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 3;
  localparam int N_FLAG = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_GRA  = 3'd5;

  typedef enum logic [1:0] {
    CLR_FREE = 2'd0,
    CLR_ON_A = 2'd1,
    CLR_ON_B = 2'd2,
    CLR_SYNC = 2'd3
  } clr_mode_e;

  // packed: bits 7:6 clr, 5:4 edge_sel, 3:1 src, 0 run
  typedef struct packed {
    logic [1:0] clr;
    logic [1:0] edge_sel;
    logic [2:0] src;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int N_EXT = 4,
  parameter int N_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_clk,
  input  logic [2:0]       src,
  input  logic [1:0]       edge_sel,
  output logic             tick
);
  localparam int DIV_W = N_DIV - 1;
  localparam int IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [N_EXT-1:0] s1_q, s2_q, s3_q;
  logic [N_EXT-1:0] rise, fall;
  logic [IDX_W-1:0] idx;
  logic             int_tick, ext_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      s1_q  <= ext_clk;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
    end
  end

  for (genvar e = 0; e < N_EXT; e++) begin : g_edge
    assign rise[e] = s2_q[e] & ~s3_q[e];
    assign fall[e] = ~s2_q[e] & s3_q[e];
  end

  always_comb begin
    mask     = DIV_W'((32'd1 << src[1:0]) - 32'd1);
    int_tick = ((div_q & mask) == mask);
    idx      = src[IDX_W-1:0];
    case (edge_sel)
      2'b00:   ext_tick = rise[idx];
      2'b01:   ext_tick = fall[idx];
      default: ext_tick = rise[idx] | fall[idx];
    endcase
    tick = src[2] ? ext_tick : int_tick;
  end

  // R2
  div8_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (src == 3'd3 && tick) |=> !(tick && src == 3'd3));
endmodule

// File: rtl/cct_gr_unit.sv
module cct_gr_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [2:0]   mode,
  input  logic         pin_in,
  input  logic         wr_gr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] gr_q,
  output logic         hit,
  output logic         pin_q
);
  logic p1_q, p2_q, p3_q;
  logic rise, fall, cap_edge, cmp_hit, cap_hit;

  always_comb begin
    rise = p2_q & ~p3_q;
    fall = ~p2_q & p3_q;
    if (mode[1])      cap_edge = rise | fall;
    else if (mode[0]) cap_edge = fall;
    else              cap_edge = rise;
    cmp_hit = run & tick & ~mode[2] & (cnt == gr_q);
    cap_hit = run & mode[2] & cap_edge;
    hit     = cmp_hit | cap_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q  <= 1'b0;
      p2_q  <= 1'b0;
      p3_q  <= 1'b0;
      gr_q  <= '0;
      pin_q <= 1'b0;
    end else begin
      p1_q <= pin_in;
      p2_q <= p1_q;
      p3_q <= p2_q;
      if (wr_gr)        gr_q <= wdata;
      else if (cap_hit) gr_q <= cnt;
      if (cmp_hit) begin
        case (mode[1:0])
          2'b01:   pin_q <= 1'b0;
          2'b10:   pin_q <= 1'b1;
          2'b11:   pin_q <= ~pin_q;
          default: pin_q <= pin_q;
        endcase
      end
    end
  end

  // R6
  drive_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && mode == 3'b001) |=> !pin_q);
  // R6
  drive_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && mode == 3'b010) |=> pin_q);
  // R7
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_hit && !wr_gr) |=> gr_q == $past(cnt));
  // R1
  idle_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pin_q));
endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_EXT = 4,
  parameter int N_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_EXT-1:0]  ext_clk,
  input  logic [1:0]        cap_in,
  output logic [1:0]        cmp_out,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_ovf
);
  ctrl_t                         ctrl_q;
  logic [N_GR-1:0][MODE_W-1:0]   mode_q;
  logic [N_FLAG-1:0]             ien_q, ien_n, flag_q, flag_n, set_v, clr_v, irq_q;
  logic [CNT_W-1:0]              cnt_q, cnt_n, rd_mux;
  logic [N_GR-1:0][CNT_W-1:0]    gr_q;
  logic [N_GR-1:0]               gr_hit, wr_gr;
  logic                          tick, cnt_tick, clr_hit, ovf_ev;
  logic                          wr_ctrl, wr_mode, wr_stat, wr_ien, wr_cnt;
  clr_mode_e                     clr_mode;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_ien  = bus_wr && bus_addr == A_IEN;
  assign wr_cnt  = bus_wr && bus_addr == A_CNT;

  cct_prescaler #(.N_EXT(N_EXT), .N_DIV(N_DIV)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .ext_clk  (ext_clk),
    .src      (ctrl_q.src),
    .edge_sel (ctrl_q.edge_sel),
    .tick     (tick)
  );

  for (genvar g = 0; g < N_GR; g++) begin : g_gr
    assign wr_gr[g] = bus_wr && bus_addr == ADDR_W'(A_GRA + g);
    cct_gr_unit #(.W(CNT_W)) u_gr (
      .clk    (clk),
      .rst    (rst),
      .run    (ctrl_q.run),
      .tick   (tick),
      .cnt    (cnt_q),
      .mode   (mode_q[g]),
      .pin_in (cap_in[g]),
      .wr_gr  (wr_gr[g]),
      .wdata  (bus_wdata),
      .gr_q   (gr_q[g]),
      .hit    (gr_hit[g]),
      .pin_q  (cmp_out[g])
    );
  end

  always_comb begin
    clr_mode = clr_mode_e'(ctrl_q.clr);
    cnt_tick = ctrl_q.run & tick;
    clr_hit  = (clr_mode == CLR_ON_A && gr_hit[0]) ||
               (clr_mode == CLR_ON_B && gr_hit[1]);
    ovf_ev   = cnt_tick && !clr_hit && !wr_cnt && (&cnt_q);

    cnt_n = cnt_q;
    if (wr_cnt)        cnt_n = bus_wdata;
    else if (clr_hit)  cnt_n = '0;
    else if (cnt_tick) cnt_n = cnt_q + 1'b1;

    set_v  = {ovf_ev, gr_hit[1], gr_hit[0]};
    clr_v  = wr_stat ? ~bus_wdata[N_FLAG-1:0] : '0;
    flag_n = set_v | (flag_q & ~clr_v);
    ien_n  = wr_ien ? bus_wdata[N_FLAG-1:0] : ien_q;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: rd_mux = CNT_W'(ctrl_q);
      A_MODE: for (int g = 0; g < N_GR; g++) rd_mux[4*g +: MODE_W] = mode_q[g];
      A_STAT: rd_mux[N_FLAG-1:0] = flag_q;
      A_IEN:  rd_mux[N_FLAG-1:0] = ien_q;
      A_CNT:  rd_mux = cnt_q;
      default:
        for (int g = 0; g < N_GR; g++)
          if (bus_addr == ADDR_W'(A_GRA + g)) rd_mux = gr_q[g];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mode_q    <= '0;
      ien_q     <= '0;
      flag_q    <= '0;
      cnt_q     <= '0;
      irq_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
      if (wr_mode)
        for (int g = 0; g < N_GR; g++) mode_q[g] <= bus_wdata[4*g +: MODE_W];
      ien_q     <= ien_n;
      flag_q    <= flag_n;
      cnt_q     <= cnt_n;
      irq_q     <= flag_n & ien_n;
      bus_rdata <= rd_mux;
    end
  end

  assign irq_a   = irq_q[0];
  assign irq_b   = irq_q[1];
  assign irq_ovf = irq_q[2];

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_cnt) |=> cnt_q == $past(cnt_q));
  // R10
  cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(bus_wdata));
  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> (cnt_q == '0 && flag_q[2]));
  // R5
  self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !wr_cnt) |=> cnt_q == '0);
  // R8
  flag_a_set_chk: assert property (@(posedge clk) disable iff (rst)
    gr_hit[0] |=> flag_q[0]);
  // R8
  flag_b_set_chk: assert property (@(posedge clk) disable iff (rst)
    gr_hit[1] |=> flag_q[1]);
endmodule

// File: tb/tb_cmpcap_timer.sv
`timescale 1ns/1ps
module tb_cmpcap_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd4;
  logic [15:0] bus_wdata = '0;
  logic [3:0]  ext_clk = '0;
  logic [1:0]  cap_in = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  cmp_out;
  logic        irq_a, irq_b, irq_ovf;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  cmpcap_timer dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq_a(irq_a), .irq_b(irq_b),
    .irq_ovf(irq_ovf)
  );

  // behavioural reference
  int m_cnt, m_div, m_rdata, m_sel, m_edge, m_clr;
  int m_gr[2];
  int m_mode[2];
  bit m_run;
  bit m_flag[3];
  bit m_ien[3];
  bit m_irq[3];
  bit m_pin[2];
  bit [3:0] e1, e2, e3;
  bit [1:0] c1, c2, c3;

  always @(posedge clk) begin : model
    int rd, nc, idx;
    bit tk, r, f, clr, wc, ovf;
    bit ev[2];
    if (rst) begin
      m_cnt = 0; m_div = 0; m_rdata = 0; m_sel = 0; m_edge = 0; m_clr = 0;
      m_run = 0;
      for (int i = 0; i < 2; i++) begin m_gr[i] = 0; m_mode[i] = 0; m_pin[i] = 0; end
      for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_ien[i] = 0; m_irq[i] = 0; end
      e1 = 0; e2 = 0; e3 = 0; c1 = 0; c2 = 0; c3 = 0;
    end else begin
      case (bus_addr)
        3'd0: rd = int'(m_run) + m_sel * 2 + m_edge * 16 + m_clr * 64;
        3'd1: rd = m_mode[0] + m_mode[1] * 16;
        3'd2: rd = int'(m_flag[0]) + 2 * int'(m_flag[1]) + 4 * int'(m_flag[2]);
        3'd3: rd = int'(m_ien[0]) + 2 * int'(m_ien[1]) + 4 * int'(m_ien[2]);
        3'd4: rd = m_cnt;
        3'd5: rd = m_gr[0];
        3'd6: rd = m_gr[1];
        default: rd = 0;
      endcase
      if (m_sel < 4) tk = ((m_div + 1) % (1 << m_sel)) == 0;
      else begin
        idx = m_sel - 4;
        r = e2[idx] && !e3[idx];
        f = !e2[idx] && e3[idx];
        tk = (m_edge == 0) ? r : (m_edge == 1) ? f : (r || f);
      end
      for (int g = 0; g < 2; g++) begin
        if (m_mode[g] < 4) ev[g] = m_run && tk && (m_cnt == m_gr[g]);
        else begin
          r = c2[g] && !c3[g];
          f = !c2[g] && c3[g];
          ev[g] = m_run && ((m_mode[g] == 4) ? r : (m_mode[g] == 5) ? f : (r || f));
        end
      end
      clr = (m_clr == 1 && ev[0]) || (m_clr == 2 && ev[1]);
      wc  = bus_wr && bus_addr == 3'd4;
      ovf = m_run && tk && !clr && !wc && m_cnt == 65535;
      if (wc) nc = int'(bus_wdata);
      else if (clr) nc = 0;
      else if (m_run && tk) nc = (m_cnt + 1) % 65536;
      else nc = m_cnt;
      for (int g = 0; g < 2; g++) begin
        if (bus_wr && bus_addr == 3'(5 + g)) m_gr[g] = int'(bus_wdata);
        else if (m_mode[g] >= 4 && ev[g]) m_gr[g] = m_cnt;
        if (ev[g] && m_mode[g] < 4) begin
          if (m_mode[g] == 1) m_pin[g] = 0;
          else if (m_mode[g] == 2) m_pin[g] = 1;
          else if (m_mode[g] == 3) m_pin[g] = !m_pin[g];
        end
      end
      if (bus_wr && bus_addr == 3'd2)
        for (int k = 0; k < 3; k++) if (!bus_wdata[k]) m_flag[k] = 0;
      if (ev[0]) m_flag[0] = 1;
      if (ev[1]) m_flag[1] = 1;
      if (ovf)   m_flag[2] = 1;
      if (bus_wr && bus_addr == 3'd3)
        for (int k = 0; k < 3; k++) m_ien[k] = bus_wdata[k];
      if (bus_wr && bus_addr == 3'd0) begin
        m_run = bus_wdata[0]; m_sel = int'(bus_wdata[3:1]);
        m_edge = int'(bus_wdata[5:4]); m_clr = int'(bus_wdata[7:6]);
      end
      if (bus_wr && bus_addr == 3'd1) begin
        m_mode[0] = int'(bus_wdata[2:0]); m_mode[1] = int'(bus_wdata[6:4]);
      end
      for (int k = 0; k < 3; k++) m_irq[k] = m_flag[k] && m_ien[k];
      m_cnt = nc;
      m_rdata = rd;
      e3 = e2; e2 = e1; e1 = ext_clk;
      c3 = c2; c2 = c1; c1 = cap_in;
      m_div = (m_div + 1) % 8;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (bus_rdata !== m_rdata[15:0] || cmp_out !== {m_pin[1], m_pin[0]} ||
          {irq_ovf, irq_b, irq_a} !== {m_irq[2], m_irq[1], m_irq[0]}) begin
        miscompares++;
        $display("FAIL %s: rdata=%h pins=%b irq=%b%b%b expected rdata=%h pins=%b irq=%b%b%b",
                 cur_req, bus_rdata, cmp_out, irq_ovf, irq_b, irq_a,
                 m_rdata[15:0], {m_pin[1], m_pin[0]}, m_irq[2], m_irq[1], m_irq[0]);
      end
    end
  end

  function automatic logic [15:0] ctrl(int run, int src, int edg, int clr);
    return 16'(run + src * 2 + edg * 16 + clr * 64);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); bus_addr = a;
    @(negedge clk); @(negedge clk); bus_addr = 3'd4;
  endtask

  task automatic ext_toggle(input int idx, input int n, input int half);
    repeat (n) begin idle(half); ext_clk[idx] = ~ext_clk[idx]; end
  endtask

  task automatic cap_toggle(input int idx, input int n, input int half);
    repeat (n) begin idle(half); cap_in[idx] = ~cap_in[idx]; end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    cur_req = "R11";
    for (int a = 0; a < 7; a++) rd(3'(a));
    cur_req = "R2";
    wr(3'd3, 16'h0007);
    for (int s = 0; s < 4; s++) begin wr(3'd0, ctrl(1, s, 0, 0)); idle(40); end
    cur_req = "R10";
    wr(3'd4, 16'hFFF0);
    idle(3);
    cur_req = "R4";
    idle(25);
    wr(3'd0, ctrl(1, 0, 0, 3));
    wr(3'd4, 16'hFFFA);
    idle(20);
    cur_req = "R8";
    wr(3'd2, 16'h0007);
    rd(3'd2);
    wr(3'd2, 16'h0000);
    rd(3'd2);
    cur_req = "R5";
    wr(3'd5, 16'd5);
    wr(3'd1, 16'h0003);
    wr(3'd0, ctrl(1, 0, 0, 1));
    idle(40);
    wr(3'd0, ctrl(1, 1, 0, 1));
    idle(40);
    cur_req = "R6";
    wr(3'd6, 16'd7);
    wr(3'd5, 16'd2);
    wr(3'd1, 16'h0021);
    wr(3'd0, ctrl(1, 0, 0, 2));
    idle(30);
    wr(3'd1, 16'h0030);
    idle(30);
    cur_req = "R1";
    wr(3'd1, 16'h0054);
    wr(3'd0, ctrl(0, 0, 0, 0));
    cap_toggle(0, 4, 4);
    cap_toggle(1, 4, 4);
    idle(10);
    rd(3'd5);
    cur_req = "R7";
    wr(3'd0, ctrl(1, 0, 0, 1));
    cap_toggle(0, 6, 7);
    cap_toggle(1, 6, 5);
    rd(3'd5); rd(3'd6);
    wr(3'd1, 16'h0066);
    cap_toggle(0, 6, 6);
    cap_toggle(1, 6, 4);
    rd(3'd5); rd(3'd6);
    cur_req = "R3";
    wr(3'd1, 16'h0000);
    for (int e = 0; e < 3; e++) begin
      wr(3'd0, ctrl(1, 5, e, 0));
      ext_toggle(1, 10, 3);
      ext_toggle(2, 6, 3);
    end
    cur_req = "R8";
    wr(3'd5, 16'd0);
    wr(3'd0, ctrl(1, 0, 0, 1));
    repeat (5) wr(3'd2, 16'h0000);
    rd(3'd2);
    cur_req = "R9";
    wr(3'd3, 16'h0000);
    idle(5);
    wr(3'd3, 16'h0005);
    idle(5);
    wr(3'd2, 16'h0000);
    idle(5);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule